// File: doc/BRIEF.md
# Synchronous Wide Link Framer

This block is the pair of end points for a short, wide link between two switches that run from the same clock. The transmit half takes packets from a switch output port as a stream of 16-bit words, each word flagged with optional start and end markers. Every cycle it drives one forward link word. That word holds the 16 data bits, a 2-bit flit-type code and two spare control bits. The flit type tells idle cycles, routing tags, packet body and end of packet apart. No synchronizer sits on the link, because both ends share one clock.

The receive half decodes the flit type of each incoming link word. It rebuilds packet boundaries and holds the flits in a small buffer for the downstream logic, which drains them with a valid/ready handshake. Each buffer slot that frees up is reported back on four reverse wires as a credit count. The transmit half keeps a matching credit counter and stops sending payload when the counter is empty. One instance holds both halves. A link is formed by wiring one instance's forward output and reverse input to the forward input and reverse output of the instance at the far end.

Both halves are small state machines. On the transmit side, TX_GAP moves to TX_PKT when a start-marked word is accepted, and TX_PKT returns to TX_GAP when an end-marked word is accepted. On the receive side, RX_CLOSED moves to RX_OPEN when a routing-tag flit arrives, and RX_OPEN returns to RX_CLOSED when an end-of-packet flit arrives.

Top module: `sync_link_framer`

## Requirements
- R1: The forward link word carries data in bits [15:0], the flit type in bits [17:16] and spare bits [19:18]. The type codes are 2'b00 idle, 2'b01 routing tag, 2'b10 packet body and 2'b11 end of packet. The spare bits are always driven to zero.
- R2: While synchronous active-high reset is applied, and on the cycle after it, the forward output is all zero and pkt_ready is high. In the same cycles out_valid is low, rev_out is zero and frame_err is low.
- R3: In TX_GAP, an accepted word with pkt_sop set is sent as a routing-tag flit and the state moves to TX_PKT. In TX_PKT, an accepted word with pkt_eop set is sent as end of packet and the state returns to TX_GAP. Any other accepted word in TX_PKT is sent as packet body. Each flit appears on fwd_out on the cycle after its acceptance.
- R4: In TX_GAP, an accepted word without pkt_sop is discarded. It produces no flit and uses no credit.
- R5: pkt_ready is high exactly when the credit count is nonzero. The count starts at DEPTH, falls by one for each non-idle flit sent and rises by rev_in each cycle. While it is zero, only idle flits are sent.
- R6: On a cycle with no flit to send, fwd_out is all zero.
- R7: Each routing-tag, body or end flit that is accepted on fwd_in is delivered on out_data in arrival order. A routing tag is delivered with out_sop set and an end-of-packet flit with out_eop set. A flit leaves the buffer on a cycle where out_valid and out_ready are both high. The buffer never overflows.
- R8: rev_out equals the number of flits that the previous cycle removed from the buffer plus the number it dropped.
- R9: A body or end-of-packet flit that arrives in RX_CLOSED is dropped, and frame_err is set. frame_err stays set until reset.
- R10: The spare bits of fwd_in have no effect on the received flit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both link ends |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Packet word offered by the switch port |
| pkt_sop | input | 1 | Word opens a packet |
| pkt_eop | input | 1 | Word closes a packet |
| pkt_data | input | 16 | Packet word |
| pkt_ready | output | 1 | Credits available, word accepted when valid |
| fwd_out | output | 20 | Forward link word sent |
| rev_in | input | 4 | Credits returned by the far receiver |
| fwd_in | input | 20 | Forward link word received |
| rev_out | output | 4 | Credits returned to the far transmitter |
| out_valid | output | 1 | Received flit available |
| out_ready | input | 1 | Downstream takes the flit |
| out_sop | output | 1 | Delivered flit is a routing tag |
| out_eop | output | 1 | Delivered flit ends a packet |
| out_data | output | 16 | Delivered flit data |
| frame_err | output | 1 | Sticky framing error |

## Verification
The assertions rely on the far end returning no more credits than this transmitter has used. The bound on the credit count and the buffer check depend on that. They also rely on a word never carrying both markers at once. The stimulus feeds the instance's own reverse output back into its reverse input and never sets pkt_sop and pkt_eop on the same word. In the phase that injects raw link words to provoke framing errors, the reverse input is forced to zero, so those flits cannot raise the credit count above its start value.

// File: rtl/slf_pkg.sv
package slf_pkg;

    typedef enum logic [1:0] {
        FT_IDLE = 2'b00,
        FT_TAG  = 2'b01,
        FT_BODY = 2'b10,
        FT_END  = 2'b11
    } flit_t;

    typedef enum logic {
        TX_GAP,
        TX_PKT
    } tx_state_t;

    typedef enum logic {
        RX_CLOSED,
        RX_OPEN
    } rx_state_t;

endpackage

// File: rtl/slf_tx.sv
module slf_tx
    import slf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int CRED_W = 4,
    localparam int LINK_W = DATA_W + 4,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic [CRED_W-1:0] credit_in,
    output logic [LINK_W-1:0] link_out,
    output logic [CNT_W-1:0]  credits_o
);
    localparam int SUM_W = CNT_W + CRED_W + 1;

    tx_state_t         state, state_nx;
    flit_t             send_type;
    logic              accept, sent;
    logic [CNT_W-1:0]  credits;
    logic [SUM_W-1:0]  credit_sum;

    assign in_ready  = (credits != '0);
    assign accept    = in_valid && in_ready;
    assign credits_o = credits;

    always_comb begin
        state_nx  = state;
        send_type = FT_IDLE;
        unique case (state)
            TX_GAP: begin
                if (accept && in_sop) begin
                    send_type = FT_TAG;
                    state_nx  = TX_PKT;
                end
            end
            TX_PKT: begin
                if (accept) begin
                    if (in_eop) begin
                        send_type = FT_END;
                        state_nx  = TX_GAP;
                    end else begin
                        send_type = FT_BODY;
                    end
                end
            end
        endcase
    end

    assign sent       = (send_type != FT_IDLE);
    assign credit_sum = SUM_W'(credits) + SUM_W'(credit_in) - SUM_W'(sent);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_GAP;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            link_out <= '0;
            credits  <= CNT_W'(DEPTH);
        end else begin
            link_out <= {2'b00, send_type, sent ? in_data : {DATA_W{1'b0}}};
            credits  <= credit_sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/slf_rx_fifo.sv
module slf_rx_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wp] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) begin
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_rd) begin
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            unique case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/slf_rx.sv
module slf_rx
    import slf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int CRED_W = 4,
    localparam int LINK_W = DATA_W + 4,
    localparam int ENT_W  = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINK_W-1:0] link_in,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data,
    output logic [CRED_W-1:0] credit_out,
    output logic              frame_err,
    output logic              buf_full,
    output logic              buf_wr
);
    rx_state_t         state, state_nx;
    flit_t             ftype;
    logic              store, drop, pop, empty;
    logic [1:0]        spare_unused;
    logic [ENT_W-1:0]  rd_ent;

    assign ftype        = flit_t'(link_in[DATA_W+1:DATA_W]);
    assign spare_unused = link_in[DATA_W+3:DATA_W+2];

    always_comb begin
        state_nx = state;
        store    = 1'b0;
        drop     = 1'b0;
        unique case (state)
            RX_CLOSED: begin
                unique case (ftype)
                    FT_TAG: begin
                        store    = 1'b1;
                        state_nx = RX_OPEN;
                    end
                    FT_BODY, FT_END: drop = 1'b1;
                    FT_IDLE: ;
                endcase
            end
            RX_OPEN: begin
                unique case (ftype)
                    FT_TAG, FT_BODY: store = 1'b1;
                    FT_END: begin
                        store    = 1'b1;
                        state_nx = RX_CLOSED;
                    end
                    FT_IDLE: ;
                endcase
            end
        endcase
    end

    assign buf_wr    = store;
    assign out_valid = !empty;
    assign pop       = out_valid && out_ready;
    assign out_sop   = rd_ent[ENT_W-1];
    assign out_eop   = rd_ent[ENT_W-2];
    assign out_data  = rd_ent[DATA_W-1:0];

    slf_rx_fifo #(
        .W     (ENT_W),
        .DEPTH (DEPTH)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (store),
        .wr_data ({ftype == FT_TAG, ftype == FT_END, link_in[DATA_W-1:0]}),
        .rd_en   (pop),
        .rd_data (rd_ent),
        .empty   (empty),
        .full    (buf_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_CLOSED;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            credit_out <= '0;
            frame_err  <= 1'b0;
        end else begin
            credit_out <= CRED_W'(pop) + CRED_W'(drop);
            if (drop) begin
                frame_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sync_link_framer.sv
module sync_link_framer #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int CRED_W = 4,
    localparam int LINK_W = DATA_W + 4,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid,
    input  logic              pkt_sop,
    input  logic              pkt_eop,
    input  logic [DATA_W-1:0] pkt_data,
    output logic              pkt_ready,
    output logic [LINK_W-1:0] fwd_out,
    input  logic [CRED_W-1:0] rev_in,
    input  logic [LINK_W-1:0] fwd_in,
    output logic [CRED_W-1:0] rev_out,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data,
    output logic              frame_err
);
    logic [CNT_W-1:0] tx_credits;
    logic             rx_full, rx_wr;

    slf_tx #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .CRED_W (CRED_W)
    ) u_tx (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (pkt_valid),
        .in_sop    (pkt_sop),
        .in_eop    (pkt_eop),
        .in_data   (pkt_data),
        .in_ready  (pkt_ready),
        .credit_in (rev_in),
        .link_out  (fwd_out),
        .credits_o (tx_credits)
    );

    slf_rx #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .CRED_W (CRED_W)
    ) u_rx (
        .clk        (clk),
        .rst        (rst),
        .link_in    (fwd_in),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_sop    (out_sop),
        .out_eop    (out_eop),
        .out_data   (out_data),
        .credit_out (rev_out),
        .frame_err  (frame_err),
        .buf_full   (rx_full),
        .buf_wr     (rx_wr)
    );

endmodule

// File: rtl/slf_checker.sv
module slf_checker #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int CRED_W = 4,
    localparam int LINK_W = DATA_W + 4,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [LINK_W-1:0] fwd_out,
    input logic              pkt_ready,
    input logic              frame_err,
    input logic [CRED_W-1:0] rev_out,
    input logic [CNT_W-1:0]  tx_credits,
    input logic              rx_full,
    input logic              rx_wr
);
    assert_spare_zero_R1: assert property (@(posedge clk) disable iff (rst)
        fwd_out[LINK_W-1:LINK_W-2] == 2'b00);

    assert_reset_idle_R2: assert property (@(posedge clk)
        rst |=> (fwd_out == '0 && rev_out == '0 && !frame_err));

    assert_credit_bound_R5: assert property (@(posedge clk) disable iff (rst)
        tx_credits <= CNT_W'(DEPTH));

    assert_stall_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !pkt_ready |=> fwd_out[DATA_W+1:DATA_W] == 2'b00);

    assert_idle_data_zero_R6: assert property (@(posedge clk) disable iff (rst)
        fwd_out[DATA_W+1:DATA_W] == 2'b00 |-> fwd_out[DATA_W-1:0] == '0);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        !(rx_wr && rx_full));

    assert_credit_range_R8: assert property (@(posedge clk) disable iff (rst)
        rev_out <= CRED_W'(2));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> frame_err);

endmodule

bind sync_link_framer slf_checker #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CRED_W (CRED_W)
) u_slf_checker (
    .clk        (clk),
    .rst        (rst),
    .fwd_out    (fwd_out),
    .pkt_ready  (pkt_ready),
    .frame_err  (frame_err),
    .rev_out    (rev_out),
    .tx_credits (tx_credits),
    .rx_full    (rx_full),
    .rx_wr      (rx_wr)
);

// File: tb/sync_link_framer_bench.sv
`timescale 1ns/1ps
module sync_link_framer_bench;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_valid = 1'b0, pkt_sop = 1'b0, pkt_eop = 1'b0;
    logic [15:0] pkt_data = '0;
    logic        pkt_ready;
    logic [19:0] fwd_out, fwd_in;
    logic [3:0]  rev_in, rev_out;
    logic        out_valid, out_sop, out_eop, frame_err;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;
    logic        inject = 1'b0;
    logic [19:0] inj_word = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int valid_pct = 100, ready_pct = 100;

    typedef struct { bit sop; bit eop; logic [15:0] d; } w_t;
    w_t          sendq[$];
    logic [17:0] rxq[$];

    int          m_cred;
    bit          m_tx_open, m_rx_open;
    logic [19:0] exp_fwd;
    logic [3:0]  exp_rev;
    bit          exp_err;

    always #2.5 clk = ~clk;

    assign fwd_in = inject ? inj_word : fwd_out;
    assign rev_in = inject ? 4'd0 : rev_out;

    sync_link_framer u_sync_link_framer (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_sop(pkt_sop),
        .pkt_eop(pkt_eop), .pkt_data(pkt_data), .pkt_ready(pkt_ready),
        .fwd_out(fwd_out), .rev_in(rev_in), .fwd_in(fwd_in), .rev_out(rev_out),
        .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
        .out_eop(out_eop), .out_data(out_data), .frame_err(frame_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Reference model, updated on every rising edge from pre-edge values
    always @(posedge clk) begin
        if (rst) begin
            m_cred = DEPTH; m_tx_open = 0; m_rx_open = 0;
            exp_fwd = '0; exp_rev = '0; exp_err = 0;
            rxq.delete();
        end else begin
            bit drop, popped, fire, sent;
            logic [1:0] ft;
            drop = 0; sent = 0;
            popped = out_valid && out_ready;
            if (popped) begin
                if (rxq.size() == 0) begin
                    chk(0, "R7 unexpected delivery", {14'd0, out_sop, out_eop, out_data}, 0);
                end else begin
                    chk({out_sop, out_eop, out_data} === rxq[0], "R7 delivered flit",
                        {14'd0, out_sop, out_eop, out_data}, {14'd0, rxq[0]});
                    void'(rxq.pop_front());
                end
            end
            ft = fwd_in[17:16];
            if (ft == 2'b01) begin
                rxq.push_back({2'b10, fwd_in[15:0]}); m_rx_open = 1;
            end else if (ft == 2'b10) begin
                if (m_rx_open) rxq.push_back({2'b00, fwd_in[15:0]}); else drop = 1;
            end else if (ft == 2'b11) begin
                if (m_rx_open) begin rxq.push_back({2'b01, fwd_in[15:0]}); m_rx_open = 0; end
                else drop = 1;
            end
            exp_rev = 4'(popped) + 4'(drop);
            if (drop) exp_err = 1;
            fire = pkt_valid && (m_cred > 0);
            exp_fwd = '0;
            if (fire) begin
                w_t w;
                w = sendq.pop_front();
                if (!m_tx_open) begin
                    if (w.sop) begin exp_fwd = {4'b0001, w.d}; m_tx_open = 1; sent = 1; end
                end else begin
                    sent = 1;
                    if (w.eop) begin exp_fwd = {4'b0011, w.d}; m_tx_open = 0; end
                    else exp_fwd = {4'b0010, w.d};
                end
            end
            m_cred = m_cred - int'(sent) + int'(rev_in);
        end
    end

    // Per-cycle compare, then drive inputs, at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                chk(pkt_ready == (m_cred > 0), "R5 ready vs credits", pkt_ready, m_cred > 0);
                chk(fwd_out === exp_fwd, "R3 R4 R6 forward word", fwd_out, exp_fwd);
                chk(out_valid == (rxq.size() > 0), "R7 out_valid", out_valid, rxq.size() > 0);
                chk(rev_out === exp_rev, "R8 credit return", rev_out, exp_rev);
                chk(frame_err == exp_err, "R9 frame_err", frame_err, exp_err);
            end
            if (sendq.size() > 0 && $urandom_range(99) < valid_pct) begin
                pkt_valid = 1; pkt_sop = sendq[0].sop; pkt_eop = sendq[0].eop; pkt_data = sendq[0].d;
            end else begin
                pkt_valid = 0; pkt_sop = 0; pkt_eop = 0; pkt_data = 16'h0;
            end
            if (!inject) out_ready = ($urandom_range(99) < ready_pct);
        end
    end

    task automatic add_pkt(input int len, input logic [15:0] base);
        for (int i = 0; i < len; i++) begin
            w_t w;
            w.sop = (i == 0); w.eop = (i == len - 1); w.d = base + 16'(i);
            sendq.push_back(w);
        end
    endtask

    task automatic settle();
        while (sendq.size() > 0 || rxq.size() > 0) @(posedge clk);
        repeat (6) @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        // R2: state held in reset
        chk(fwd_out == 20'h0, "R2 fwd_out in reset", fwd_out, 0);
        chk(pkt_ready == 1'b1, "R2 pkt_ready in reset", pkt_ready, 1);
        chk(out_valid == 1'b0, "R2 out_valid in reset", out_valid, 0);
        chk(rev_out == 4'h0, "R2 rev_out in reset", rev_out, 0);
        chk(frame_err == 1'b0, "R2 frame_err in reset", frame_err, 0);
        rst = 0;
    endtask

    initial begin
        w_t stray;
        do_reset();
        // R3, R4: stray word before a packet, then packets of several lengths
        stray.sop = 0; stray.eop = 0; stray.d = 16'hdead;
        sendq.push_back(stray);
        add_pkt(2, 16'h1000); add_pkt(3, 16'h2000); add_pkt(5, 16'h3000);
        settle();
        // R5, R7, R8: irregular offer and drain
        valid_pct = 60; ready_pct = 50;
        for (int p = 0; p < 12; p++) add_pkt(2 + p % 6, 16'h4000 + 16'(p * 16));
        settle();
        // R5: downstream stalls, credits run out
        valid_pct = 100; ready_pct = 0;
        add_pkt(20, 16'h5000);
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(pkt_ready == 1'b0, "R5 stalled with no credit", pkt_ready, 0);
        ready_pct = 100;
        settle();
        // R9, R10: raw link words with framing faults and spare bits set
        @(negedge clk); inject = 1; out_ready = 1;
        inj_word = {4'b0010, 16'h0bad};
        @(negedge clk); inj_word = {4'b1101, 16'habcd};
        @(negedge clk); inj_word = {4'b1010, 16'h1234};
        @(negedge clk); inj_word = {4'b0111, 16'h5678};
        @(negedge clk); inj_word = {4'b0011, 16'h9999};
        @(negedge clk); inj_word = 20'h0;
        repeat (6) @(negedge clk);
        chk(frame_err == 1'b1, "R9 sticky error", frame_err, 1);
        chk(rxq.size() == 0, "R10 flits with spare bits delivered", rxq.size(), 0);
        inject = 0;
        do_reset();
        @(negedge clk);
        chk(frame_err == 1'b0, "R9 cleared by reset", frame_err, 0);
        repeat (3) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule